// File: doc/BRIEF.md
# Operand Address Generator

This block turns the addressing fields of an instruction into the address of its memory operand. It takes a mode code, an operand size, the number of the address register being named, that register's current value, the value of an index register, an extension value (holding a 16-bit displacement, an 8-bit offset, or a short or long absolute address) and the updated program counter. One cycle later it presents a 24-bit operand address. For the auto-stepping modes it also presents the new value for the named address register, with a write strobe.

All arithmetic is two's complement at 32 bits. Only the address output is cut to 24 bits. The register write-back value keeps its full width. Modes that name a register or carry an immediate operand produce no memory address. For these modes the block raises a flag instead, so that the sequencer can route the operand elsewhere. The sequencer fetches the extension words and runs the memory cycle itself.

Top module: `ea_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `an_we`, `mem_ref`, `is_reg`, `is_imm` and `ea` are all zero after that edge.
- R2: Each request with `in_valid` high appears on the outputs after exactly one rising edge, with `out_valid` high for that one cycle. `an_we` is high only in a cycle where `out_valid` is high.
- R3: Mode codes are 0 data register direct, 1 address register direct, 2 immediate, 3 indirect, 4 post-increment, 5 pre-decrement, 6 indirect plus 16-bit displacement, 7 indirect plus index plus 8-bit offset, 8 absolute short, 9 absolute long, 10 PC plus 16-bit displacement, and 11 PC plus index plus 8-bit offset. For codes 0, 1 and 2, and for the unused codes 12 to 15, `mem_ref` is 0, `ea` is 0 and `an_we` is 0. `is_reg` is 1 for codes 0 and 1, and `is_imm` is 1 for code 2.
- R4: Absolute short (code 8) sign-extends `ext_val[15:0]` from bit 15. 0x8000 gives 0xFF8000, and 0x7FFE gives 0x007FFE.
- R5: Absolute long (code 9) outputs the low 24 bits of the 32-bit `ext_val`.
- R6: Indirect (code 3) outputs the low 24 bits of `areg_val`, and `an_we` stays 0.
- R7: Code 6 adds `areg_val` and the sign-extended `ext_val[15:0]` at 32 bits and outputs the low 24 bits, so the address wraps past 0xFFFFFF.
- R8: Code 7 adds `areg_val`, the full 32-bit `index_val` and the sign-extended `ext_val[7:0]`.
- R9: Post-increment (code 4) outputs `areg_val` as the address and pulses `an_we` with `an_wdata = areg_val + step`. The step is 1, 2 or 4 for size code 0 (byte), 1 (word) or 2 (long). Size code 3 steps as long.
- R10: Pre-decrement (code 5) computes `areg_val - step` and uses it as both the address (low 24 bits) and `an_wdata`, with `an_we` pulsed.
- R11: A byte-size post-increment or pre-decrement on register number 7 steps by 2.
- R12: Code 10 adds the sign-extended `ext_val[15:0]` to `pc_val`, and code 11 adds `index_val` and the sign-extended `ext_val[7:0]` to `pc_val`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 4 | Addressing mode code |
| size | input | 2 | Operand size code |
| reg_num | input | 3 | Number of the named address register |
| areg_val | input | 32 | Current value of the named address register |
| index_val | input | 32 | Index register value, full width |
| ext_val | input | 32 | Displacement, offset or absolute address |
| pc_val | input | 32 | Updated program counter |
| out_valid | output | 1 | Result registered this cycle |
| ea | output | 24 | Operand address |
| mem_ref | output | 1 | The mode refers to memory |
| is_reg | output | 1 | Register direct mode |
| is_imm | output | 1 | Immediate mode |
| an_we | output | 1 | Address register write strobe |
| an_wdata | output | 32 | New address register value |

## Verification
The bench builds the block with its defaults: a 32-bit datapath, a 24-bit address, a 3-bit register number, register 7 as the stack pointer, and stack-pointer alignment on. The 24-bit cut makes the wrap at the top of the address space observable, and it lets a negative PC-relative sum show up as a high address. With alignment on, the byte step of the stack register can be told apart from the step of an ordinary register.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int EA_DW = 32;

    localparam logic [3:0] M_DREG    = 4'd0;
    localparam logic [3:0] M_AREG    = 4'd1;
    localparam logic [3:0] M_IMM     = 4'd2;
    localparam logic [3:0] M_IND     = 4'd3;
    localparam logic [3:0] M_POST    = 4'd4;
    localparam logic [3:0] M_PRE     = 4'd5;
    localparam logic [3:0] M_DISP    = 4'd6;
    localparam logic [3:0] M_IDX     = 4'd7;
    localparam logic [3:0] M_ABSS    = 4'd8;
    localparam logic [3:0] M_ABSL    = 4'd9;
    localparam logic [3:0] M_PCDISP  = 4'd10;
    localparam logic [3:0] M_PCIDX   = 4'd11;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;

    typedef enum logic [2:0] {
        OFF_NONE, OFF_D16, OFF_D8, OFF_ABS_S, OFF_ABS_L
    } off_kind_t;

    typedef enum logic [1:0] {
        UPD_NONE, UPD_POST, UPD_PRE
    } upd_kind_t;

    typedef struct packed {
        logic      mem_ref;
        logic      is_reg;
        logic      is_imm;
        logic      base_pc;
        logic      base_areg;
        logic      add_index;
        off_kind_t off;
        upd_kind_t upd;
    } ea_dec_t;

    function automatic logic [EA_DW-1:0] sext16(input logic [15:0] v);
        return {{(EA_DW-16){v[15]}}, v};
    endfunction

    function automatic logic [EA_DW-1:0] sext8(input logic [7:0] v);
        return {{(EA_DW-8){v[7]}}, v};
    endfunction

endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
(
    input  logic [3:0] mode,
    output ea_dec_t    dec
);
    always_comb begin
        dec = '{mem_ref: 1'b0, is_reg: 1'b0, is_imm: 1'b0, base_pc: 1'b0,
                base_areg: 1'b0, add_index: 1'b0, off: OFF_NONE, upd: UPD_NONE};
        case (mode)
            M_DREG, M_AREG: dec.is_reg = 1'b1;
            M_IMM:          dec.is_imm = 1'b1;
            M_IND: begin
                dec.mem_ref = 1'b1; dec.base_areg = 1'b1;
            end
            M_POST: begin
                dec.mem_ref = 1'b1; dec.base_areg = 1'b1; dec.upd = UPD_POST;
            end
            M_PRE: begin
                dec.mem_ref = 1'b1; dec.base_areg = 1'b1; dec.upd = UPD_PRE;
            end
            M_DISP: begin
                dec.mem_ref = 1'b1; dec.base_areg = 1'b1; dec.off = OFF_D16;
            end
            M_IDX: begin
                dec.mem_ref = 1'b1; dec.base_areg = 1'b1;
                dec.add_index = 1'b1; dec.off = OFF_D8;
            end
            M_ABSS: begin
                dec.mem_ref = 1'b1; dec.off = OFF_ABS_S;
            end
            M_ABSL: begin
                dec.mem_ref = 1'b1; dec.off = OFF_ABS_L;
            end
            M_PCDISP: begin
                dec.mem_ref = 1'b1; dec.base_pc = 1'b1; dec.off = OFF_D16;
            end
            M_PCIDX: begin
                dec.mem_ref = 1'b1; dec.base_pc = 1'b1;
                dec.add_index = 1'b1; dec.off = OFF_D8;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ea_step.sv
module ea_step
    import ea_pkg::*;
#(
    parameter int DW       = 32,
    parameter int REG_W    = 3,
    parameter int SP_REG   = 7,
    parameter bit SP_ALIGN = 1'b1
) (
    input  logic [1:0]       size,
    input  logic [REG_W-1:0] reg_num,
    output logic [DW-1:0]    step
);
    logic byte_bump;

    generate
        if (SP_ALIGN) begin : g_align
            assign byte_bump = (reg_num == REG_W'(SP_REG));
        end else begin : g_plain
            assign byte_bump = 1'b0;
        end
    endgenerate

    always_comb begin
        case (size)
            SZ_BYTE: step = byte_bump ? DW'(2) : DW'(1);
            SZ_WORD: step = DW'(2);
            default: step = DW'(4);
        endcase
    end
endmodule

// File: rtl/ea_adder.sv
module ea_adder
    import ea_pkg::*;
#(
    parameter int DW = 32
) (
    input  ea_dec_t       dec,
    input  logic [DW-1:0] areg_val,
    input  logic [DW-1:0] pc_val,
    input  logic [DW-1:0] index_val,
    input  logic [DW-1:0] ext_val,
    input  logic [DW-1:0] step,
    output logic [DW-1:0] sum,
    output logic [DW-1:0] upd_val
);
    logic [DW-1:0] base_t, index_t, off_t;

    always_comb begin
        if (dec.base_pc)        base_t = pc_val;
        else if (dec.base_areg) base_t = areg_val;
        else                    base_t = '0;

        index_t = dec.add_index ? index_val : '0;

        case (dec.off)
            OFF_D16, OFF_ABS_S: off_t = DW'(sext16(ext_val[15:0]));
            OFF_D8:             off_t = DW'(sext8(ext_val[7:0]));
            OFF_ABS_L:          off_t = ext_val;
            default:            off_t = (dec.upd == UPD_PRE) ? (~step + DW'(1)) : '0;
        endcase

        sum = base_t + index_t + off_t;
        upd_val = (dec.upd == UPD_POST) ? (areg_val + step) : sum;
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
#(
    parameter int DW       = ea_pkg::EA_DW,
    parameter int ADDR_W   = 24,
    parameter int REG_W    = 3,
    parameter int SP_REG   = 7,
    parameter bit SP_ALIGN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        mode,
    input  logic [1:0]        size,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [DW-1:0]     areg_val,
    input  logic [DW-1:0]     index_val,
    input  logic [DW-1:0]     ext_val,
    input  logic [DW-1:0]     pc_val,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              mem_ref,
    output logic              is_reg,
    output logic              is_imm,
    output logic              an_we,
    output logic [DW-1:0]     an_wdata
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              mem;
        logic              rdir;
        logic              imm;
        logic              we;
        logic [DW-1:0]     wdata;
        logic [3:0]        mode;
        logic [REG_W-1:0]  rnum;
    } ea_out_t;

    ea_dec_t       dec;
    logic [DW-1:0] step, sum, upd_val;
    ea_out_t       q;

    ea_decode u_dec (.mode(mode), .dec(dec));

    ea_step #(.DW(DW), .REG_W(REG_W), .SP_REG(SP_REG), .SP_ALIGN(SP_ALIGN)) u_step (
        .size(size), .reg_num(reg_num), .step(step)
    );

    ea_adder #(.DW(DW)) u_add (
        .dec(dec), .areg_val(areg_val), .pc_val(pc_val), .index_val(index_val),
        .ext_val(ext_val), .step(step), .sum(sum), .upd_val(upd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld   <= in_valid;
            q.addr  <= dec.mem_ref ? sum[ADDR_W-1:0] : '0;
            q.mem   <= dec.mem_ref;
            q.rdir  <= dec.is_reg;
            q.imm   <= dec.is_imm;
            q.we    <= in_valid && (dec.upd != UPD_NONE);
            q.wdata <= upd_val;
            q.mode  <= mode;
            q.rnum  <= reg_num;
        end
    end

    assign out_valid = q.vld;
    assign ea        = q.addr;
    assign mem_ref   = q.mem;
    assign is_reg    = q.rdir;
    assign is_imm    = q.imm;
    assign an_we     = q.we;
    assign an_wdata  = q.wdata;

    logic [ADDR_W-1:0] step_seen;
    assign step_seen = an_wdata[ADDR_W-1:0] - ea;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !an_we && !mem_ref && ea == '0));

    assert_we_needs_valid_R2: assert property (@(posedge clk) disable iff (rst)
        an_we |-> out_valid);

    assert_nomem_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (is_reg || is_imm)) |-> (!mem_ref && ea == '0 && !an_we));

    assert_post_step_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && q.mode == M_POST) |->
            (an_we && (step_seen == ADDR_W'(1) || step_seen == ADDR_W'(2) ||
                       step_seen == ADDR_W'(4))));

    assert_pre_same_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && q.mode == M_PRE) |-> (an_we && an_wdata[ADDR_W-1:0] == ea));

    assert_sp_even_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && q.mode == M_POST && q.rnum == REG_W'(SP_REG) && SP_ALIGN)
            |-> (step_seen != ADDR_W'(1)));
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [2:0]  reg_num = '0;
    logic [31:0] areg_val = '0, index_val = '0, ext_val = '0, pc_val = '0;
    logic        out_valid, mem_ref, is_reg, is_imm, an_we;
    logic [23:0] ea;
    logic [31:0] an_wdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ea_gen dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .size(size),
        .reg_num(reg_num), .areg_val(areg_val), .index_val(index_val),
        .ext_val(ext_val), .pc_val(pc_val), .out_valid(out_valid), .ea(ea),
        .mem_ref(mem_ref), .is_reg(is_reg), .is_imm(is_imm), .an_we(an_we),
        .an_wdata(an_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] m, input logic [1:0] s, input logic [2:0] r,
                         input logic [31:0] a, input logic [31:0] x,
                         input logic [31:0] e, input logic [31:0] p);
        @(negedge clk);
        mode = m; size = s; reg_num = r; areg_val = a; index_val = x;
        ext_val = e; pc_val = p; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 an_we", 32'(an_we), 0);
        chk("R1 ea", 32'(ea), 0);
        chk("R1 mem_ref", 32'(mem_ref), 0);
    endtask

    task automatic t_latency;
        apply(4'd3, 2'd1, 3'd1, 32'h0000_4000, 0, 0, 0);
        chk("R2 out_valid", 32'(out_valid), 1);
        @(negedge clk);
        chk("R2 out_valid drop", 32'(out_valid), 0);
        chk("R2 an_we idle", 32'(an_we), 0);
    endtask

    task automatic t_nomem;
        apply(4'd0, 2'd2, 3'd2, 32'h0012_3456, 0, 32'h1234, 0);
        chk("R3 dreg ea", 32'(ea), 0);
        chk("R3 dreg is_reg", 32'(is_reg), 1);
        chk("R3 dreg mem_ref", 32'(mem_ref), 0);
        apply(4'd1, 2'd2, 3'd2, 32'h0012_3456, 0, 0, 0);
        chk("R3 areg is_reg", 32'(is_reg), 1);
        chk("R3 areg an_we", 32'(an_we), 0);
        apply(4'd2, 2'd1, 3'd0, 32'h0000_0100, 0, 32'hAABB, 0);
        chk("R3 imm is_imm", 32'(is_imm), 1);
        chk("R3 imm ea", 32'(ea), 0);
        apply(4'd13, 2'd1, 3'd0, 32'h0000_0100, 0, 32'hAABB, 0);
        chk("R3 unused mem_ref", 32'(mem_ref), 0);
        chk("R3 unused ea", 32'(ea), 0);
        chk("R3 unused an_we", 32'(an_we), 0);
    endtask

    task automatic t_abs;
        apply(4'd8, 2'd1, 3'd0, 32'h0011_1111, 0, 32'h0000_8000, 0);
        chk("R4 neg short", 32'(ea), 32'h00FF_8000);
        chk("R4 mem_ref", 32'(mem_ref), 1);
        apply(4'd8, 2'd1, 3'd0, 32'h0011_1111, 0, 32'hFFFF_7FFE, 0);
        chk("R4 pos short", 32'(ea), 32'h0000_7FFE);
        apply(4'd9, 2'd2, 3'd0, 0, 0, 32'h1234_5678, 0);
        chk("R5 long", 32'(ea), 32'h0034_5678);
    endtask

    task automatic t_areg_modes;
        apply(4'd3, 2'd2, 3'd4, 32'h55AB_CDEF, 0, 0, 0);
        chk("R6 indirect", 32'(ea), 32'h00AB_CDEF);
        chk("R6 no write", 32'(an_we), 0);
        apply(4'd6, 2'd1, 3'd1, 32'h0000_1000, 0, 32'h0000_FFF0, 0);
        chk("R7 neg disp", 32'(ea), 32'h0000_0FF0);
        chk("R7 no write", 32'(an_we), 0);
        apply(4'd6, 2'd1, 3'd1, 32'h00FF_FFF0, 0, 32'h0000_0020, 0);
        chk("R7 wrap", 32'(ea), 32'h0000_0010);
        apply(4'd7, 2'd1, 3'd1, 32'h0000_2000, 32'h0000_0100, 32'h0000_0080, 0);
        chk("R8 neg offset", 32'(ea), 32'h0000_2080);
        apply(4'd7, 2'd1, 3'd1, 32'h0000_2000, 32'hFFFF_FFFC, 32'h0000_0004, 0);
        chk("R8 neg index", 32'(ea), 32'h0000_2000);
    endtask

    task automatic t_post;
        logic [31:0] inc [4] = '{32'h101, 32'h102, 32'h104, 32'h104};
        for (int s = 0; s < 4; s++) begin
            apply(4'd4, 2'(s), 3'd3, 32'h0000_0100, 0, 0, 0);
            chk("R9 post ea", 32'(ea), 32'h100);
            chk("R9 post we", 32'(an_we), 1);
            chk("R9 post wdata", an_wdata, inc[s]);
        end
    endtask

    task automatic t_pre;
        apply(4'd5, 2'd1, 3'd2, 32'h0000_0200, 0, 0, 0);
        chk("R10 word ea", 32'(ea), 32'h1FE);
        chk("R10 word wdata", an_wdata, 32'h1FE);
        chk("R10 we", 32'(an_we), 1);
        apply(4'd5, 2'd2, 3'd2, 32'h0000_0200, 0, 0, 0);
        chk("R10 long ea", 32'(ea), 32'h1FC);
        apply(4'd5, 2'd0, 3'd0, 32'h0000_0200, 0, 0, 0);
        chk("R10 byte ea", 32'(ea), 32'h1FF);
        chk("R10 byte wdata", an_wdata, 32'h1FF);
    endtask

    task automatic t_stack;
        apply(4'd4, 2'd0, 3'd7, 32'h0000_0400, 0, 0, 0);
        chk("R11 post sp ea", 32'(ea), 32'h400);
        chk("R11 post sp wdata", an_wdata, 32'h402);
        apply(4'd5, 2'd0, 3'd7, 32'h0000_0400, 0, 0, 0);
        chk("R11 pre sp ea", 32'(ea), 32'h3FE);
        chk("R11 pre sp wdata", an_wdata, 32'h3FE);
    endtask

    task automatic t_pcrel;
        apply(4'd10, 2'd2, 3'd0, 32'h0077_0000, 0, 32'h0000_8000, 32'h0000_1000);
        chk("R12 pc disp neg", 32'(ea), 32'h00FF_9000);
        apply(4'd10, 2'd2, 3'd0, 32'h0077_0000, 0, 32'h0000_0040, 32'h0000_1000);
        chk("R12 pc disp pos", 32'(ea), 32'h0000_1040);
        apply(4'd11, 2'd1, 3'd0, 32'h0077_0000, 32'h0000_0010, 32'h0000_00FE, 32'h0000_0500);
        chk("R12 pc index", 32'(ea), 32'h0000_050E);
        chk("R12 no write", 32'(an_we), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_latency();
        t_nomem();
        t_abs();
        t_areg_modes();
        t_post();
        t_pre();
        t_stack();
        t_pcrel();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule